// File: doc/BRIEF.md
# Direction-Aware Compare Counter

This block is a parameterised up/down counter, 16 bits wide by default. An upstream phase decoder supplies its count strobes and a direction flag. On every strobe the counter steps by one in the flagged direction. Two compare registers and an external clear line can instead force the count to zero or load a new value. How they do so depends on a personality bit.

- **Personality A (mode bit 0):** a 2-bit select picks which events may zero the counter. An underflow reloads the counter from compare register 0.
- **Personality B (mode bit 1):** each compare register acts in one direction only:
  - Compare register 0 zeroes the counter when counting up.
  - Compare register 1 zeroes the counter when counting down.
  - Each such clear raises a one-clock interrupt pulse for that register.

The external clear is asynchronous to the block clock. It passes through a synchroniser and a rising-edge detector before it can act. Compare matches are judged on the count value held when the strobe arrives. A clear takes the place of that strobe's step.

Top module: `updn_cmp_timer`

## Requirements
- R1: After reset the count is 0 and both interrupt outputs are low.
- R2: With no clear or reload taking effect, a strobe with `cntUp`=1 adds one and a strobe with `cntUp`=0 subtracts one, one clock after the strobe. Counting up from all-ones wraps to 0. In personality B, counting down from 0 wraps to all-ones.
- R3: Without a strobe or an effective clear, the count holds its value.
- R4: In personality A with `clrSel`=01 (compare-match source), an up strobe while count equals `cmp0` zeroes the counter instead of incrementing. A down strobe at that value decrements normally.
- R5: In personality A, a down strobe while the count is 0 loads `cmp0` into the counter.
- R6: In personality A, a rising edge on `extClr` zeroes the counter after synchronisation when `clrSel` is 00 (external only) or 10 (external or match). With `clrSel` 01 or 11, or in personality B, the edge has no effect.
- R7: With `clrSel`=11, no source clears the counter. An up strobe at `cmp0` increments.
- R8: In personality B, an up strobe while count equals `cmp0` zeroes the counter and pulses `irq0` high for exactly one clock.
- R9: In personality B, a down strobe while count equals `cmp0` only decrements, and `irq0` stays low.
- R10: In personality B, a down strobe while count equals `cmp1` zeroes the counter and pulses `irq1` high for exactly one clock.
- R11: In personality B, an up strobe while count equals `cmp1` only increments, and `irq1` stays low.
- R12: When an effective external clear and a strobe reach the counter in the same cycle, the result is 0.
- R13: In personality A neither interrupt output is ever raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cntStrobe | input | 1 | One-clock count request from the decoder |
| cntUp | input | 1 | Direction of the request: 1 up, 0 down |
| modeSel | input | 1 | Personality: 0 selects A, 1 selects B |
| clrSel | input | 2 | Personality-A clear source: 00 external, 01 match, 10 either, 11 none |
| extClr | input | 1 | Asynchronous external clear, acts on its rising edge |
| cmp0 | input | W | Compare register 0 |
| cmp1 | input | W | Compare register 1 |
| count | output | W | Current counter value |
| irq0 | output | 1 | One-clock pulse on a personality-B compare-0 clear |
| irq1 | output | 1 | One-clock pulse on a personality-B compare-1 clear |

## Verification
The bench builds the block with its defaults: a 16-bit count and a two-stage clear synchroniser. At this width, the personality-A underflow reload can place the counter next to all-ones in a single strobe. Both wrap boundaries and every compare corner case are therefore reached in a few clocks, without counting through the range. The two-stage synchroniser gives a fixed three-clock path from a clear edge to the counter. This latency lets the bench line a strobe up exactly with the clear to check the priority rule.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;

  // Clear-source encodings for personality A
  localparam logic [1:0] CLR_EXT   = 2'b00;
  localparam logic [1:0] CLR_MATCH = 2'b01;
  localparam logic [1:0] CLR_BOTH  = 2'b10;
  localparam logic [1:0] CLR_NONE  = 2'b11;

  // Action strobes sent from control to datapath
  typedef struct packed {
    logic doClear;
    logic doReload;
    logic doInc;
    logic doDec;
    logic pulse0;
    logic pulse1;
  } ctlStrobes_t;

endpackage

// File: rtl/clr_edge_sync.sv
module clr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic risePulse
);

  logic [STAGES-1:0] shreg;
  logic              lastQ;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) shreg <= '0;
        else       shreg <= asyncIn;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) shreg <= '0;
        else       shreg <= {shreg[STAGES-2:0], asyncIn};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastQ <= 1'b0;
    else       lastQ <= shreg[STAGES-1];
  end

  assign risePulse = shreg[STAGES-1] & ~lastQ;

  // R6: the detected edge lasts one cycle only
  a_r6_edge_single: assert property (@(posedge clk) disable iff (!rstN)
    risePulse |=> !risePulse);

endmodule

// File: rtl/updn_timer_ctrl.sv
module updn_timer_ctrl
  import updn_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cntStrobe,
  input  logic         cntUp,
  input  logic         modeSel,
  input  logic [1:0]   clrSel,
  input  logic         clrPulse,
  input  logic [W-1:0] count,
  input  logic [W-1:0] cmp0,
  input  logic [W-1:0] cmp1,
  output ctlStrobes_t  ctl
);

  logic match0, match1, atZero;
  logic extHit, cmpHit;

  assign match0 = (count == cmp0);
  assign match1 = (count == cmp1);
  assign atZero = (count == '0);

  // Personality A clear qualifiers
  assign extHit = clrPulse && ((clrSel == CLR_EXT) || (clrSel == CLR_BOTH));
  assign cmpHit = cntStrobe && cntUp && match0 &&
                  ((clrSel == CLR_MATCH) || (clrSel == CLR_BOTH));

  always_comb begin
    ctl = '0;
    if (!modeSel) begin
      if (extHit || cmpHit) begin
        ctl.doClear = 1'b1;
      end else if (cntStrobe) begin
        if (cntUp)       ctl.doInc    = 1'b1;
        else if (atZero) ctl.doReload = 1'b1;
        else             ctl.doDec    = 1'b1;
      end
    end else if (cntStrobe) begin
      if (cntUp && match0) begin
        ctl.doClear = 1'b1;
        ctl.pulse0  = 1'b1;
      end else if (!cntUp && match1) begin
        ctl.doClear = 1'b1;
        ctl.pulse1  = 1'b1;
      end else if (cntUp) begin
        ctl.doInc = 1'b1;
      end else begin
        ctl.doDec = 1'b1;
      end
    end
  end

  // R3: at most one counter action per cycle
  a_r3_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.doClear, ctl.doReload, ctl.doInc, ctl.doDec}));

  // R5: reload only on a personality-A down step from zero
  a_r5_reload_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doReload |-> (!modeSel && !cntUp && cntStrobe && count == '0));

  // R13: no interrupt requests in personality A
  a_r13_quiet_mode_a: assert property (@(posedge clk) disable iff (!rstN)
    !modeSel |-> !(ctl.pulse0 || ctl.pulse1));

endmodule

// File: rtl/updn_timer_datapath.sv
module updn_timer_datapath
  import updn_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctlStrobes_t  ctl,
  input  logic [W-1:0] cmp0,
  output logic [W-1:0] count,
  output logic         irq0,
  output logic         irq1
);

  logic [W-1:0] countNext;
  logic         anyAction;

  assign anyAction = ctl.doClear | ctl.doReload | ctl.doInc | ctl.doDec;

  always_comb begin
    countNext = count;
    if (ctl.doClear)       countNext = '0;
    else if (ctl.doReload) countNext = cmp0;
    else if (ctl.doInc)    countNext = count + 1'b1;
    else if (ctl.doDec)    countNext = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      irq0  <= 1'b0;
      irq1  <= 1'b0;
    end else begin
      count <= countNext;
      irq0  <= ctl.pulse0;
      irq1  <= ctl.pulse1;
    end
  end

  // R8: compare-0 interrupt lasts a single clock
  a_r8_irq0_single: assert property (@(posedge clk) disable iff (!rstN)
    irq0 |=> !irq0);

  // R10: compare-1 interrupt lasts a single clock
  a_r10_irq1_single: assert property (@(posedge clk) disable iff (!rstN)
    irq1 |=> !irq1);

  // R8, R10: an interrupt always coincides with a zeroed count
  a_r8_irq_zero: assert property (@(posedge clk) disable iff (!rstN)
    (irq0 || irq1) |-> (count == '0));

  // R3: no action, no change
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    !anyAction |=> $stable(count));

endmodule

// File: rtl/updn_cmp_timer.sv
module updn_cmp_timer
  import updn_timer_pkg::*;
#(
  parameter int W          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cntStrobe,
  input  logic         cntUp,
  input  logic         modeSel,
  input  logic [1:0]   clrSel,
  input  logic         extClr,
  input  logic [W-1:0] cmp0,
  input  logic [W-1:0] cmp1,
  output logic [W-1:0] count,
  output logic         irq0,
  output logic         irq1
);

  logic        clrPulse;
  ctlStrobes_t ctl;

  clr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rstN     (rstN),
    .asyncIn  (extClr),
    .risePulse(clrPulse)
  );

  updn_timer_ctrl #(.W(W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cntStrobe(cntStrobe),
    .cntUp    (cntUp),
    .modeSel  (modeSel),
    .clrSel   (clrSel),
    .clrPulse (clrPulse),
    .count    (count),
    .cmp0     (cmp0),
    .cmp1     (cmp1),
    .ctl      (ctl)
  );

  updn_timer_datapath #(.W(W)) u_dp (
    .clk  (clk),
    .rstN (rstN),
    .ctl  (ctl),
    .cmp0 (cmp0),
    .count(count),
    .irq0 (irq0),
    .irq1 (irq1)
  );

endmodule

// File: tb/tb_updn_cmp_timer.sv
module tb_updn_cmp_timer;

  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cntStrobe = 1'b0;
  logic         cntUp = 1'b0;
  logic         modeSel = 1'b0;
  logic [1:0]   clrSel = 2'b11;
  logic         extClr = 1'b0;
  logic [W-1:0] cmp0 = '0;
  logic [W-1:0] cmp1 = '0;
  logic [W-1:0] count;
  logic         irq0, irq1;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  updn_cmp_timer #(.W(W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rstN(rstN), .cntStrobe(cntStrobe), .cntUp(cntUp),
    .modeSel(modeSel), .clrSel(clrSel), .extClr(extClr),
    .cmp0(cmp0), .cmp1(cmp1), .count(count), .irq0(irq0), .irq1(irq1)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic up);
    @(negedge clk);
    cntStrobe = 1'b1;
    cntUp     = up;
    @(negedge clk);
    cntStrobe = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulseClear();
    @(negedge clk);
    extClr = 1'b1;
    idle(4);
    extClr = 1'b0;
    idle(3);
  endtask

  // Put an arbitrary value in the counter via clear then underflow reload
  task automatic loadVal(input logic [W-1:0] v);
    @(negedge clk);
    modeSel = 1'b0;
    clrSel  = 2'b00;
    pulseClear();
    cmp0   = v;
    clrSel = 2'b11;
    step(1'b0);
  endtask

  task automatic testReset();
    check("R1 count", count, 0);
    check("R1 irq0", irq0, 0);
    check("R1 irq1", irq1, 0);
  endtask

  task automatic testHoldAndStep();
    loadVal(16'd5);
    check("R5 reload", count, 16'd5);
    idle(5);
    check("R3 hold", count, 16'd5);
    step(1'b1);
    check("R2 inc", count, 16'd6);
    step(1'b0);
    check("R2 dec", count, 16'd5);
  endtask

  task automatic testWrapUpNoClear();
    loadVal(16'hFFFE);
    step(1'b1);
    check("R7 match no clear", count, 16'hFFFF);
    step(1'b1);
    check("R2 up wrap", count, 16'h0000);
  endtask

  task automatic testMatchClearA();
    loadVal(16'd10);
    clrSel = 2'b01;
    step(1'b1);
    check("R4 up match clear", count, 0);
    check("R13 irq0 in A", irq0, 0);
    loadVal(16'd11);
    cmp0   = 16'd10;
    clrSel = 2'b01;
    step(1'b0);
    check("R4 down to match", count, 16'd10);
    step(1'b0);
    check("R4 down at match", count, 16'd9);
  endtask

  task automatic testExtClearSel();
    loadVal(16'd40);
    clrSel = 2'b01;
    pulseClear();
    check("R6 sel01 ignored", count, 16'd40);
    clrSel = 2'b11;
    pulseClear();
    check("R6 sel11 ignored", count, 16'd40);
    modeSel = 1'b1;
    clrSel  = 2'b00;
    pulseClear();
    check("R6 mode B ignored", count, 16'd40);
    modeSel = 1'b0;
    clrSel  = 2'b10;
    pulseClear();
    check("R6 sel10 clears", count, 0);
  endtask

  task automatic testPriority();
    loadVal(16'd70);
    clrSel = 2'b00;
    @(negedge clk);
    extClr = 1'b1;
    @(negedge clk);
    @(negedge clk);
    cntStrobe = 1'b1;
    cntUp     = 1'b1;
    @(negedge clk);
    cntStrobe = 1'b0;
    check("R12 clear beats strobe", count, 0);
    extClr = 1'b0;
    idle(3);
  endtask

  task automatic testModeBUp();
    loadVal(16'd20);
    modeSel = 1'b1;
    cmp0 = 16'd21;
    cmp1 = 16'd100;
    step(1'b1);
    check("R2 B inc", count, 16'd21);
    step(1'b1);
    check("R8 clear", count, 0);
    check("R8 irq0 high", irq0, 1);
    @(negedge clk);
    check("R8 irq0 low", irq0, 0);
  endtask

  task automatic testModeBDownCmp0();
    loadVal(16'd30);
    modeSel = 1'b1;
    cmp0 = 16'd30;
    cmp1 = 16'd5;
    step(1'b0);
    check("R9 dec", count, 16'd29);
    check("R9 irq0", irq0, 0);
  endtask

  task automatic testModeBDownCmp1();
    loadVal(16'd6);
    modeSel = 1'b1;
    cmp0 = 16'd200;
    cmp1 = 16'd5;
    step(1'b0);
    check("R2 B dec", count, 16'd5);
    step(1'b0);
    check("R10 clear", count, 0);
    check("R10 irq1 high", irq1, 1);
    @(negedge clk);
    check("R10 irq1 low", irq1, 0);
    cmp1 = 16'd100;
    cmp0 = 16'd50;
    step(1'b0);
    check("R2 B down wrap", count, 16'hFFFF);
  endtask

  task automatic testModeBUpCmp1();
    loadVal(16'd5);
    modeSel = 1'b1;
    cmp0 = 16'd300;
    cmp1 = 16'd5;
    step(1'b1);
    check("R11 inc", count, 16'd6);
    check("R11 irq1", irq1, 0);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testHoldAndStep();
    testWrapUpNoClear();
    testMatchClearA();
    testExtClearSel();
    testPriority();
    testModeBUp();
    testModeBDownCmp0();
    testModeBDownCmp1();
    testModeBUpCmp1();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule